// File: doc/BRIEF.md
# Chained-Die Address Router

This block sits at the inbound memory-mapped port of one memory die in a chain of identical dies. A host reaches every die through the first one. Each request address carries a die number in its top bits. The router compares that number with the die's strap pins. On a hit, it clears the die number, keeps the in-die offset, and steers the request to the local memory port or the local register port. On a miss, it forwards the request unchanged to the downstream port toward the next die. Dies are numbered from 0 upward, moving away from the host, so a three-bit strap addresses eight dies.

Requests and responses are single-beat and use valid/ready channels. There are five upstream channels: write address, write data, write response, read address and read data. On the target side there is one shared payload bus per channel, with a separate valid/ready pair for each of the three targets. Index 0 is memory, index 1 is registers and index 2 is downstream.

Back-pressure rules:
- Any side may hold ready low for as long as it likes.
- A valid, once raised, stays high with a stable payload until its handshake.
- The router takes one write and one read at a time. It records the target chosen for each, and the response comes back from that target only.

Top module: `chain_addr_router`

## Requirements
- R1: When address bits [23:21] equal `chip_id`, the request goes to a local port with bits [23:21] cleared and bits [20:0] unchanged. Write and read channels decide independently.
- R2: When bits [23:21] differ from `chip_id`, the request goes to target index 2 (downstream) with all 24 address bits unchanged.
- R3: A local offset in 0x1F0000..0x1FFFFF goes to target index 1 (registers).
- R4: A local offset below 0x1F0000 whose bank number (offset bits [20:17]) is 14 or less goes to target index 0 (memory).
- R5: A local offset in 0x1E0000..0x1EFFFF (bank 15) raises no target valid. The router answers it with response code 2'b10. A read of such an offset returns data 0.
- R6: A write reaches a target only after both its address and its data have been accepted upstream, in either order. Data and byte strobes pass through unchanged.
- R7: From the acceptance of a write until its upstream response handshake, `up_aw_ready` and `up_w_ready` are low. `up_ar_ready` behaves the same way for a read.
- R8: Each target's 2-bit response code, and its read data, reach upstream unchanged, and only for the request sent to that target.
- R9: Every valid the router drives stays high, with a stable payload, until its ready is seen.
- R10: After reset, all router-driven valids are low, and `up_aw_ready`, `up_w_ready` and `up_ar_ready` are high.
- R11: A read completes while a write is stalled waiting for its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chip_id | input | 3 | Strap value naming this die |
| up_aw_valid | input | 1 | Upstream write address valid |
| up_aw_ready | output | 1 | Upstream write address ready |
| up_aw_addr | input | 24 | Upstream write address |
| up_w_valid | input | 1 | Upstream write data valid |
| up_w_ready | output | 1 | Upstream write data ready |
| up_w_data | input | 32 | Upstream write data |
| up_w_strb | input | 4 | Upstream byte strobes |
| up_b_valid | output | 1 | Upstream write response valid |
| up_b_ready | input | 1 | Upstream write response ready |
| up_b_resp | output | 2 | Upstream write response code |
| up_ar_valid | input | 1 | Upstream read address valid |
| up_ar_ready | output | 1 | Upstream read address ready |
| up_ar_addr | input | 24 | Upstream read address |
| up_r_valid | output | 1 | Upstream read data valid |
| up_r_ready | input | 1 | Upstream read data ready |
| up_r_data | output | 32 | Upstream read data |
| up_r_resp | output | 2 | Upstream read response code |
| tgt_wr_valid | output | 3 | Per-target write request valid |
| tgt_wr_ready | input | 3 | Per-target write request ready |
| tgt_wr_addr | output | 24 | Shared write address (remapped or forwarded) |
| tgt_wr_data | output | 32 | Shared write data |
| tgt_wr_strb | output | 4 | Shared byte strobes |
| tgt_b_valid | input | 3 | Per-target write response valid |
| tgt_b_ready | output | 3 | Per-target write response ready |
| tgt_b_resp | input | 3x2 | Per-target write response code |
| tgt_rd_valid | output | 3 | Per-target read request valid |
| tgt_rd_ready | input | 3 | Per-target read request ready |
| tgt_rd_addr | output | 24 | Shared read address |
| tgt_r_valid | input | 3 | Per-target read data valid |
| tgt_r_ready | output | 3 | Per-target read data ready |
| tgt_r_data | input | 3x32 | Per-target read data |
| tgt_r_resp | input | 3x2 | Per-target read response code |

## Verification
The strap is fixed at 2, and addresses are driven with die numbers 2, 5 and 0. This separates a hit from a miss on both channels. Local offsets fall on the edges of each window:
- 0x1DFFFF and 0x1E0000 show where the last real bank ends and the missing bank begins.
- 0x1EFFFF and 0x1F0000 show where the missing bank gives way to the register window.
- 0x1FFFFF is the top of the register window.

Writes present address and data together, address first and data first. This shows whether a write can leak to a target before both halves arrive. Targets give each index its own response code and a data word built from the received address, so a misrouted reply is seen at the upstream port. A write left waiting for its address while a read runs shows whether the two directions are independent.

// File: rtl/chain_router_pkg.sv
package chain_router_pkg;

  localparam int unsigned ROUTE_TARGETS = 3;

  typedef enum logic [1:0] {
    TGT_MEM = 2'd0,
    TGT_REG = 2'd1,
    TGT_DN  = 2'd2,
    TGT_ERR = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_ISSUE   = 2'd1,
    PH_WAIT    = 2'd2,
    PH_REPLY   = 2'd3
  } phase_e;

  localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/chain_route_decode.sv
module chain_route_decode
  import chain_router_pkg::*;
#(
  parameter int unsigned ID_W      = 3,
  parameter int unsigned OFFS_W    = 21,
  parameter int unsigned REG_BASE  = 32'h1F0000,
  parameter int unsigned BANK_LSB  = 17,
  parameter int unsigned NUM_BANKS = 15,
  localparam int unsigned ADDR_W   = ID_W + OFFS_W,
  localparam int unsigned BANK_W   = OFFS_W - BANK_LSB
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ID_W-1:0]   die_id,
  output tgt_e              route,
  output logic [ADDR_W-1:0] out_addr
);

  logic [OFFS_W-1:0] offs;
  logic [BANK_W-1:0] bank;
  logic              hit;

  assign offs = req_addr[OFFS_W-1:0];
  assign bank = offs[OFFS_W-1:BANK_LSB];
  assign hit  = (req_addr[ADDR_W-1:OFFS_W] == die_id);

  always_comb begin
    out_addr = req_addr;
    route    = TGT_DN;
    if (hit) begin
      out_addr = {{ID_W{1'b0}}, offs};
      if (offs >= OFFS_W'(REG_BASE)) begin
        route = TGT_REG;
      end else if (32'(bank) >= NUM_BANKS) begin
        route = TGT_ERR;
      end else begin
        route = TGT_MEM;
      end
    end
  end

endmodule

// File: rtl/chain_wr_path.sv
module chain_wr_path
  import chain_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned OFFS_W    = 21,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BANK_LSB  = 17,
  parameter int unsigned NUM_BANKS = 15,
  parameter int unsigned NT        = 3,
  localparam int unsigned STRB_W   = DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  aw_valid,
  output logic                  aw_ready,
  input  tgt_e                  aw_route,
  input  logic [ADDR_W-1:0]     aw_addr,
  input  logic                  w_valid,
  output logic                  w_ready,
  input  logic [DATA_W-1:0]     w_data,
  input  logic [STRB_W-1:0]     w_strb,
  output logic                  b_valid,
  input  logic                  b_ready,
  output logic [1:0]            b_resp,
  output logic [NT-1:0]         t_valid,
  input  logic [NT-1:0]         t_ready,
  output logic [ADDR_W-1:0]     t_addr,
  output logic [DATA_W-1:0]     t_data,
  output logic [STRB_W-1:0]     t_strb,
  input  logic [NT-1:0]         tb_valid,
  output logic [NT-1:0]         tb_ready,
  input  logic [NT-1:0][1:0]    tb_resp
);

  phase_e             ph;
  tgt_e               tgt_q;
  logic               aw_held, w_held;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [STRB_W-1:0]  strb_q;
  logic [1:0]         resp_q;
  logic               aw_fire, w_fire, aw_have, w_have;
  logic               sel_ready, sel_bvalid;
  logic [1:0]         sel_bresp;
  tgt_e               next_tgt;

  assign aw_ready = (ph == PH_COLLECT) && !aw_held;
  assign w_ready  = (ph == PH_COLLECT) && !w_held;
  assign aw_fire  = aw_valid && aw_ready;
  assign w_fire   = w_valid && w_ready;
  assign aw_have  = aw_held || aw_fire;
  assign w_have   = w_held || w_fire;
  assign next_tgt = aw_fire ? aw_route : tgt_q;

  for (genvar i = 0; i < NT; i++) begin : g_tgt
    assign t_valid[i]  = (ph == PH_ISSUE) && (tgt_q == tgt_e'(i));
    assign tb_ready[i] = (ph == PH_WAIT)  && (tgt_q == tgt_e'(i));
  end

  always_comb begin
    sel_ready  = 1'b0;
    sel_bvalid = 1'b0;
    sel_bresp  = '0;
    for (int i = 0; i < NT; i++) begin
      if (tgt_q == tgt_e'(i)) begin
        sel_ready  = t_ready[i];
        sel_bvalid = tb_valid[i];
        sel_bresp  = tb_resp[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_COLLECT;
      tgt_q   <= TGT_MEM;
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      strb_q  <= '0;
      resp_q  <= '0;
    end else begin
      unique case (ph)
        PH_COLLECT: begin
          if (aw_fire) begin
            aw_held <= 1'b1;
            addr_q  <= aw_addr;
            tgt_q   <= aw_route;
          end
          if (w_fire) begin
            w_held <= 1'b1;
            data_q <= w_data;
            strb_q <= w_strb;
          end
          if (aw_have && w_have) begin
            if (next_tgt == TGT_ERR) begin
              resp_q <= RESP_SLVERR;
              ph     <= PH_REPLY;
            end else begin
              ph <= PH_ISSUE;
            end
          end
        end
        PH_ISSUE: if (sel_ready) ph <= PH_WAIT;
        PH_WAIT: begin
          if (sel_bvalid) begin
            resp_q <= sel_bresp;
            ph     <= PH_REPLY;
          end
        end
        PH_REPLY: begin
          if (b_ready) begin
            ph      <= PH_COLLECT;
            aw_held <= 1'b0;
            w_held  <= 1'b0;
          end
        end
        default: ph <= PH_COLLECT;
      endcase
    end
  end

  assign b_valid = (ph == PH_REPLY);
  assign b_resp  = resp_q;
  assign t_addr  = addr_q;
  assign t_data  = data_q;
  assign t_strb  = strb_q;

  // R9: a write request held by a target keeps its valid and payload
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(t_valid & ~t_ready)) |=> (t_valid == $past(t_valid)) && $stable(t_addr)
                                && $stable(t_data) && $stable(t_strb));

  // R9: a write response waits upstream with a stable code
  p_b_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> b_valid && $stable(b_resp));

  // R1: local write targets see the die number cleared
  p_wr_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|t_valid[1:0]) |-> (t_addr[ADDR_W-1:OFFS_W] == '0));

  // R5: the memory port never sees a missing bank
  p_wr_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid[0] |-> (32'(t_addr[OFFS_W-1:BANK_LSB]) < NUM_BANKS));

  // R7: no new write accepted while one is with a target
  p_wr_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|t_valid) |-> !aw_ready && !w_ready);

endmodule

// File: rtl/chain_rd_path.sv
module chain_rd_path
  import chain_router_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned OFFS_W    = 21,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BANK_LSB  = 17,
  parameter int unsigned NUM_BANKS = 15,
  parameter int unsigned NT        = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ar_valid,
  output logic                      ar_ready,
  input  tgt_e                      ar_route,
  input  logic [ADDR_W-1:0]         ar_addr,
  output logic                      r_valid,
  input  logic                      r_ready,
  output logic [DATA_W-1:0]         r_data,
  output logic [1:0]                r_resp,
  output logic [NT-1:0]             t_valid,
  input  logic [NT-1:0]             t_ready,
  output logic [ADDR_W-1:0]         t_addr,
  input  logic [NT-1:0]             tr_valid,
  output logic [NT-1:0]             tr_ready,
  input  logic [NT-1:0][DATA_W-1:0] tr_data,
  input  logic [NT-1:0][1:0]        tr_resp
);

  phase_e            ph;
  tgt_e              tgt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        resp_q;
  logic              ar_fire;
  logic              sel_ready, sel_rvalid;
  logic [DATA_W-1:0] sel_rdata;
  logic [1:0]        sel_rresp;

  assign ar_ready = (ph == PH_COLLECT);
  assign ar_fire  = ar_valid && ar_ready;

  for (genvar i = 0; i < NT; i++) begin : g_tgt
    assign t_valid[i]  = (ph == PH_ISSUE) && (tgt_q == tgt_e'(i));
    assign tr_ready[i] = (ph == PH_WAIT)  && (tgt_q == tgt_e'(i));
  end

  always_comb begin
    sel_ready  = 1'b0;
    sel_rvalid = 1'b0;
    sel_rdata  = '0;
    sel_rresp  = '0;
    for (int i = 0; i < NT; i++) begin
      if (tgt_q == tgt_e'(i)) begin
        sel_ready  = t_ready[i];
        sel_rvalid = tr_valid[i];
        sel_rdata  = tr_data[i];
        sel_rresp  = tr_resp[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_COLLECT;
      tgt_q  <= TGT_MEM;
      addr_q <= '0;
      data_q <= '0;
      resp_q <= '0;
    end else begin
      unique case (ph)
        PH_COLLECT: begin
          if (ar_fire) begin
            addr_q <= ar_addr;
            tgt_q  <= ar_route;
            if (ar_route == TGT_ERR) begin
              data_q <= '0;
              resp_q <= RESP_SLVERR;
              ph     <= PH_REPLY;
            end else begin
              ph <= PH_ISSUE;
            end
          end
        end
        PH_ISSUE: if (sel_ready) ph <= PH_WAIT;
        PH_WAIT: begin
          if (sel_rvalid) begin
            data_q <= sel_rdata;
            resp_q <= sel_rresp;
            ph     <= PH_REPLY;
          end
        end
        PH_REPLY: if (r_ready) ph <= PH_COLLECT;
        default: ph <= PH_COLLECT;
      endcase
    end
  end

  assign r_valid = (ph == PH_REPLY);
  assign r_data  = data_q;
  assign r_resp  = resp_q;
  assign t_addr  = addr_q;

  // R9: a read request held by a target keeps its valid and address
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(t_valid & ~t_ready)) |=> (t_valid == $past(t_valid)) && $stable(t_addr));

  // R9: read data waits upstream unchanged
  p_r_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> r_valid && $stable(r_data) && $stable(r_resp));

  // R1: local read targets see the die number cleared
  p_rd_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|t_valid[1:0]) |-> (t_addr[ADDR_W-1:OFFS_W] == '0));

  // R5: the memory port never sees a missing bank
  p_rd_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid[0] |-> (32'(t_addr[OFFS_W-1:BANK_LSB]) < NUM_BANKS));

  // R7: no new read accepted until the current one is answered
  p_rd_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|t_valid) || r_valid) |-> !ar_ready);

  // R9: one target at a time on the read side
  p_rd_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tr_ready | t_valid));

endmodule

// File: rtl/chain_addr_router.sv
module chain_addr_router
  import chain_router_pkg::*;
#(
  parameter int unsigned ID_W      = 3,
  parameter int unsigned OFFS_W    = 21,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_BASE  = 32'h1F0000,
  parameter int unsigned BANK_LSB  = 17,
  parameter int unsigned NUM_BANKS = 15,
  localparam int unsigned ADDR_W   = ID_W + OFFS_W,
  localparam int unsigned STRB_W   = DATA_W / 8,
  localparam int unsigned NT       = ROUTE_TARGETS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ID_W-1:0]           chip_id,
  input  logic                      up_aw_valid,
  output logic                      up_aw_ready,
  input  logic [ADDR_W-1:0]         up_aw_addr,
  input  logic                      up_w_valid,
  output logic                      up_w_ready,
  input  logic [DATA_W-1:0]         up_w_data,
  input  logic [STRB_W-1:0]         up_w_strb,
  output logic                      up_b_valid,
  input  logic                      up_b_ready,
  output logic [1:0]                up_b_resp,
  input  logic                      up_ar_valid,
  output logic                      up_ar_ready,
  input  logic [ADDR_W-1:0]         up_ar_addr,
  output logic                      up_r_valid,
  input  logic                      up_r_ready,
  output logic [DATA_W-1:0]         up_r_data,
  output logic [1:0]                up_r_resp,
  output logic [NT-1:0]             tgt_wr_valid,
  input  logic [NT-1:0]             tgt_wr_ready,
  output logic [ADDR_W-1:0]         tgt_wr_addr,
  output logic [DATA_W-1:0]         tgt_wr_data,
  output logic [STRB_W-1:0]         tgt_wr_strb,
  input  logic [NT-1:0]             tgt_b_valid,
  output logic [NT-1:0]             tgt_b_ready,
  input  logic [NT-1:0][1:0]        tgt_b_resp,
  output logic [NT-1:0]             tgt_rd_valid,
  input  logic [NT-1:0]             tgt_rd_ready,
  output logic [ADDR_W-1:0]         tgt_rd_addr,
  input  logic [NT-1:0]             tgt_r_valid,
  output logic [NT-1:0]             tgt_r_ready,
  input  logic [NT-1:0][DATA_W-1:0] tgt_r_data,
  input  logic [NT-1:0][1:0]        tgt_r_resp
);

  tgt_e              aw_route, ar_route;
  logic [ADDR_W-1:0] aw_local, ar_local;

  chain_route_decode #(
    .ID_W(ID_W), .OFFS_W(OFFS_W), .REG_BASE(REG_BASE),
    .BANK_LSB(BANK_LSB), .NUM_BANKS(NUM_BANKS)
  ) u_aw_dec (
    .req_addr(up_aw_addr), .die_id(chip_id),
    .route(aw_route), .out_addr(aw_local)
  );

  chain_route_decode #(
    .ID_W(ID_W), .OFFS_W(OFFS_W), .REG_BASE(REG_BASE),
    .BANK_LSB(BANK_LSB), .NUM_BANKS(NUM_BANKS)
  ) u_ar_dec (
    .req_addr(up_ar_addr), .die_id(chip_id),
    .route(ar_route), .out_addr(ar_local)
  );

  chain_wr_path #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W),
    .BANK_LSB(BANK_LSB), .NUM_BANKS(NUM_BANKS), .NT(NT)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(up_aw_valid), .aw_ready(up_aw_ready),
    .aw_route(aw_route), .aw_addr(aw_local),
    .w_valid(up_w_valid), .w_ready(up_w_ready),
    .w_data(up_w_data), .w_strb(up_w_strb),
    .b_valid(up_b_valid), .b_ready(up_b_ready), .b_resp(up_b_resp),
    .t_valid(tgt_wr_valid), .t_ready(tgt_wr_ready),
    .t_addr(tgt_wr_addr), .t_data(tgt_wr_data), .t_strb(tgt_wr_strb),
    .tb_valid(tgt_b_valid), .tb_ready(tgt_b_ready), .tb_resp(tgt_b_resp)
  );

  chain_rd_path #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W),
    .BANK_LSB(BANK_LSB), .NUM_BANKS(NUM_BANKS), .NT(NT)
  ) u_rd (
    .clk(clk), .rst_n(rst_n),
    .ar_valid(up_ar_valid), .ar_ready(up_ar_ready),
    .ar_route(ar_route), .ar_addr(ar_local),
    .r_valid(up_r_valid), .r_ready(up_r_ready),
    .r_data(up_r_data), .r_resp(up_r_resp),
    .t_valid(tgt_rd_valid), .t_ready(tgt_rd_ready), .t_addr(tgt_rd_addr),
    .tr_valid(tgt_r_valid), .tr_ready(tgt_r_ready),
    .tr_data(tgt_r_data), .tr_resp(tgt_r_resp)
  );

  // R2: a forwarded request keeps a die number other than this one
  p_dn_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr_valid[2] |-> (tgt_wr_addr[ADDR_W-1:OFFS_W] != chip_id));

  // R6: nothing is issued on the write side while a response is waiting upstream
  p_wr_reply_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    up_b_valid |-> (tgt_wr_valid == '0) && (tgt_b_ready == '0));

endmodule

// File: tb/chain_addr_router_tb_top.sv
`timescale 1ns/1ps
module chain_addr_router_tb_top;

  localparam logic [2:0] STRAP = 3'd2;

  typedef struct packed {
    logic [1:0]  t;
    logic [23:0] a;
    logic [31:0] d;
    logic [3:0]  s;
  } iss_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        up_aw_valid = 0, up_w_valid = 0, up_ar_valid = 0;
  logic        up_b_ready = 0, up_r_ready = 0;
  logic [23:0] up_aw_addr = '0, up_ar_addr = '0;
  logic [31:0] up_w_data = '0;
  logic [3:0]  up_w_strb = '0;
  logic        up_aw_ready, up_w_ready, up_ar_ready, up_b_valid, up_r_valid;
  logic [1:0]  up_b_resp, up_r_resp;
  logic [31:0] up_r_data;
  logic [2:0]  tgt_wr_valid, tgt_b_ready, tgt_rd_valid, tgt_r_ready;
  logic [2:0]  tgt_wr_ready = '0, tgt_rd_ready = '0;
  logic [2:0]  tgt_b_valid = '0, tgt_r_valid = '0;
  logic [2:0][1:0]  tgt_b_resp = '0, tgt_r_resp = '0;
  logic [2:0][31:0] tgt_r_data = '0;
  logic [23:0] tgt_wr_addr, tgt_rd_addr;
  logic [31:0] tgt_wr_data;
  logic [3:0]  tgt_wr_strb;

  chain_addr_router dut_i (
    .clk(clk), .rst_n(rst_n), .chip_id(STRAP),
    .up_aw_valid(up_aw_valid), .up_aw_ready(up_aw_ready), .up_aw_addr(up_aw_addr),
    .up_w_valid(up_w_valid), .up_w_ready(up_w_ready),
    .up_w_data(up_w_data), .up_w_strb(up_w_strb),
    .up_b_valid(up_b_valid), .up_b_ready(up_b_ready), .up_b_resp(up_b_resp),
    .up_ar_valid(up_ar_valid), .up_ar_ready(up_ar_ready), .up_ar_addr(up_ar_addr),
    .up_r_valid(up_r_valid), .up_r_ready(up_r_ready),
    .up_r_data(up_r_data), .up_r_resp(up_r_resp),
    .tgt_wr_valid(tgt_wr_valid), .tgt_wr_ready(tgt_wr_ready),
    .tgt_wr_addr(tgt_wr_addr), .tgt_wr_data(tgt_wr_data), .tgt_wr_strb(tgt_wr_strb),
    .tgt_b_valid(tgt_b_valid), .tgt_b_ready(tgt_b_ready), .tgt_b_resp(tgt_b_resp),
    .tgt_rd_valid(tgt_rd_valid), .tgt_rd_ready(tgt_rd_ready), .tgt_rd_addr(tgt_rd_addr),
    .tgt_r_valid(tgt_r_valid), .tgt_r_ready(tgt_r_ready),
    .tgt_r_data(tgt_r_data), .tgt_r_resp(tgt_r_resp)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  iss_t        wq[$];
  iss_t        rq[$];
  logic [1:0]  bq[$];
  logic [33:0] rdq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // Route from the requirements: 0 mem, 1 reg, 2 downstream, 3 error
  function automatic logic [1:0] route(input logic [23:0] a, output logic [23:0] la);
    if (a[23:21] != STRAP) begin
      la = a;
      return 2'd2;
    end
    la = {3'b000, a[20:0]};
    if (a[20:16] == 5'h1F) return 2'd1;
    if (a[20:17] == 4'hF)  return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [1:0] resp_of(input int t);
    case (t)
      0: return 2'b00;
      1: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [31:0] rdata_of(input int t, input logic [23:0] a);
    return {8'hC0 + 8'(t), a};
  endfunction

  // ---------------- target models and scoreboard monitor ----------------
  int cyc = 0;
  always begin
    bit [2:0] whs, rhs, bhs, rrhs;
    logic [23:0] rad [3];
    @(negedge clk);
    whs = '0; rhs = '0; bhs = '0; rrhs = '0;
    if (rst_n) begin
      for (int t = 0; t < 3; t++) begin
        if (tgt_wr_valid[t] && tgt_wr_ready[t]) begin
          iss_t e;
          whs[t] = 1'b1;
          if (wq.size() == 0) begin
            chk(0, "R5 R6", "unexpected write issue", 64'(tgt_wr_addr), 64'd0);
          end else begin
            e = wq.pop_front();
            chk(e.t == 2'(t) && e.a == tgt_wr_addr && e.d == tgt_wr_data && e.s == tgt_wr_strb,
                "R1 R2 R3 R4 R6", "write issue {t,addr,data}",
                {6'd0, 2'(t), tgt_wr_addr, tgt_wr_data}, {6'd0, e.t, e.a, e.d});
          end
        end
        if (tgt_rd_valid[t] && tgt_rd_ready[t]) begin
          iss_t e;
          rhs[t] = 1'b1;
          rad[t] = tgt_rd_addr;
          if (rq.size() == 0) begin
            chk(0, "R5", "unexpected read issue", 64'(tgt_rd_addr), 64'd0);
          end else begin
            e = rq.pop_front();
            chk(e.t == 2'(t) && e.a == tgt_rd_addr, "R1 R2 R3 R4", "read issue {t,addr}",
                {38'd0, 2'(t), tgt_rd_addr}, {38'd0, e.t, e.a});
          end
        end
        bhs[t]  = tgt_b_valid[t] && tgt_b_ready[t];
        rrhs[t] = tgt_r_valid[t] && tgt_r_ready[t];
      end
      if (up_b_valid && up_b_ready) begin
        logic [1:0] eb;
        if (bq.size() == 0) chk(0, "R8", "unexpected write response", 64'(up_b_resp), 64'd0);
        else begin
          eb = bq.pop_front();
          chk(up_b_resp == eb, "R5 R8", "write response code", 64'(up_b_resp), 64'(eb));
        end
      end
      if (up_r_valid && up_r_ready) begin
        logic [33:0] er;
        if (rdq.size() == 0) chk(0, "R8", "unexpected read response", 64'(up_r_data), 64'd0);
        else begin
          er = rdq.pop_front();
          chk({up_r_resp, up_r_data} == er, "R5 R8", "read response {resp,data}",
              64'({up_r_resp, up_r_data}), 64'(er));
        end
      end
    end
    @(posedge clk);
    #1;
    cyc++;
    for (int t = 0; t < 3; t++) begin
      if (bhs[t]) tgt_b_valid[t] = 1'b0;
      if (whs[t]) begin
        tgt_b_valid[t] = 1'b1;
        tgt_b_resp[t]  = resp_of(t);
      end
      if (rrhs[t]) tgt_r_valid[t] = 1'b0;
      if (rhs[t]) begin
        tgt_r_valid[t] = 1'b1;
        tgt_r_resp[t]  = resp_of(t);
        tgt_r_data[t]  = rdata_of(t, rad[t]);
      end
      tgt_wr_ready[t] = ((cyc + t) % 3) != 0;
      tgt_rd_ready[t] = ((cyc + t) % 4) != 1;
    end
    up_b_ready = (cyc % 3) != 2;
    up_r_ready = (cyc % 5) != 0;
  end

  // R9: stalled target requests keep their payload (checked at the ports)
  logic        pw_stall = 0, pr_stall = 0;
  logic [2:0]  pw_v, pr_v;
  logic [59:0] pw_pay;
  logic [23:0] pr_a;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pw_stall)
        chk(tgt_wr_valid == pw_v && {tgt_wr_addr, tgt_wr_data, tgt_wr_strb} == pw_pay,
            "R9", "held write request", 64'({tgt_wr_addr, tgt_wr_data}), 64'(pw_pay[59:4]));
      if (pr_stall)
        chk(tgt_rd_valid == pr_v && tgt_rd_addr == pr_a, "R9", "held read request",
            64'(tgt_rd_addr), 64'(pr_a));
      pw_stall = |(tgt_wr_valid & ~tgt_wr_ready);
      pw_v = tgt_wr_valid;
      pw_pay = {tgt_wr_addr, tgt_wr_data, tgt_wr_strb};
      pr_stall = |(tgt_rd_valid & ~tgt_rd_ready);
      pr_v = tgt_rd_valid;
      pr_a = tgt_rd_addr;
    end
  end

  // ---------------- driver ----------------
  task automatic send_aw(input logic [23:0] a);
    bit got;
    up_aw_addr = a; up_aw_valid = 1'b1;
    do begin
      @(negedge clk); got = up_aw_ready;
      @(posedge clk); #1;
    end while (!got);
    up_aw_valid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    bit got;
    up_w_data = d; up_w_strb = s; up_w_valid = 1'b1;
    do begin
      @(negedge clk); got = up_w_ready;
      @(posedge clk); #1;
    end while (!got);
    up_w_valid = 1'b0;
  endtask

  task automatic send_ar(input logic [23:0] a);
    bit got;
    up_ar_addr = a; up_ar_valid = 1'b1;
    do begin
      @(negedge clk); got = up_ar_ready;
      @(posedge clk); #1;
    end while (!got);
    up_ar_valid = 1'b0;
  endtask

  task automatic expect_write(input logic [23:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [23:0] la;
    logic [1:0] t;
    t = route(a, la);
    if (t != 2'd3) wq.push_back('{t: t, a: la, d: d, s: s});
    bq.push_back(t == 2'd3 ? 2'b10 : resp_of(int'(t)));
  endtask

  task automatic gap_no_issue(input string what);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tgt_wr_valid == 3'b000, "R6", what, 64'(tgt_wr_valid), 64'd0);
      @(posedge clk); #1;
    end
  endtask

  // order 0: together, 1: address first, 2: data first
  task automatic do_write(input logic [23:0] a, input logic [31:0] d,
                          input logic [3:0] s, input int order);
    expect_write(a, d, s);
    if (order == 0) begin
      fork
        send_aw(a);
        send_w(d, s);
      join
      @(negedge clk);
      chk(!up_aw_ready && !up_w_ready, "R7", "write channels busy after accept",
          64'({up_aw_ready, up_w_ready}), 64'd0);
      @(posedge clk); #1;
    end else if (order == 1) begin
      send_aw(a);
      gap_no_issue("issue with address only");
      send_w(d, s);
    end else begin
      send_w(d, s);
      gap_no_issue("issue with data only");
      send_aw(a);
    end
  endtask

  task automatic do_read(input logic [23:0] a);
    logic [23:0] la;
    logic [1:0] t;
    t = route(a, la);
    if (t != 2'd3) begin
      rq.push_back('{t: t, a: la, d: '0, s: '0});
      rdq.push_back({resp_of(int'(t)), rdata_of(int'(t), la)});
    end else begin
      rdq.push_back({2'b10, 32'd0});
    end
    send_ar(a);
  endtask

  task automatic drain(input int max_cyc);
    for (int k = 0; k < max_cyc; k++) begin
      if (wq.size() == 0 && rq.size() == 0 && bq.size() == 0 && rdq.size() == 0) break;
      @(posedge clk); #1;
    end
  endtask

  logic [23:0] addrs [10];
  initial begin
    addrs[0] = {3'd2, 21'h000040};  // mem (R4)
    addrs[1] = {3'd2, 21'h1F0010};  // reg (R3)
    addrs[2] = {3'd5, 21'h1F0010};  // other die (R2)
    addrs[3] = {3'd0, 21'h000100};  // die 0 (R2)
    addrs[4] = {3'd2, 21'h1E8000};  // bank 15 (R5)
    addrs[5] = {3'd2, 21'h1DFFFF};  // last real bank (R4)
    addrs[6] = {3'd2, 21'h1EFFFF};  // top of bank 15 (R5)
    addrs[7] = {3'd2, 21'h1F0000};  // register base (R3)
    addrs[8] = {3'd2, 21'h1FFFFF};  // register top (R3)
    addrs[9] = {3'd2, 21'h1E0000};  // first address of bank 15 (R5)

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(tgt_wr_valid == 0 && tgt_rd_valid == 0 && !up_b_valid && !up_r_valid,
        "R10", "valids in reset", 64'({tgt_wr_valid, tgt_rd_valid, up_b_valid, up_r_valid}), 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(up_aw_ready && up_w_ready && up_ar_ready, "R10", "upstream readies after reset",
        64'({up_aw_ready, up_w_ready, up_ar_ready}), 64'h7);
    chk(tgt_wr_valid == 0 && tgt_rd_valid == 0 && tgt_b_ready == 0 && tgt_r_ready == 0,
        "R10", "target side idle after reset", 64'({tgt_wr_valid, tgt_rd_valid}), 64'd0);
    @(posedge clk); #1;

    for (int i = 0; i < 10; i++)
      do_write(addrs[i], 32'h1000_0000 + 32'(i) * 32'h0101_0101, 4'(i + 3), i % 3);
    drain(80);
    for (int i = 0; i < 10; i++) do_read(addrs[i]);
    drain(80);

    // R11: write stalled waiting for its address while a read completes
    expect_write({3'd2, 21'h000200}, 32'hCAFE_F00D, 4'hF);
    send_w(32'hCAFE_F00D, 4'hF);
    do_read({3'd2, 21'h1F0020});
    for (int k = 0; k < 40; k++) begin
      if (rdq.size() == 0) break;
      @(posedge clk); #1;
    end
    chk(rdq.size() == 0, "R11", "read finished beside stalled write", 64'(rdq.size()), 64'd0);
    chk(tgt_wr_valid == 0 && bq.size() == 1, "R11", "stalled write still pending",
        64'(bq.size()), 64'd1);
    send_aw({3'd2, 21'h000200});
    drain(80);

    // concurrent traffic to different targets
    fork
      do_write({3'd7, 21'h0ABCDE}, 32'h5A5A_A5A5, 4'b0101, 0);
      do_read({3'd2, 21'h020000});
    join
    fork
      do_write({3'd2, 21'h1F8000}, 32'h0F0F_0F0F, 4'b1000, 0);
      do_read({3'd6, 21'h1E8000});
    join
    drain(120);

    chk(wq.size() == 0 && rq.size() == 0, "R8", "all target issues seen",
        64'(wq.size() + rq.size()), 64'd0);
    chk(bq.size() == 0 && rdq.size() == 0, "R8", "all responses returned",
        64'(bq.size() + rdq.size()), 64'd0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

endmodule